// File: doc/BRIEF.md
# Self-Test Pattern Loop (Generator and Checker)

This block provides a built-in link self-test. On the transmit side, the register that normally holds the outgoing symbol becomes a 9-bit maximal-length LFSR while self-test is selected. Each state of that register is mapped to one symbol, which is a data byte, a special character or an explicit violation symbol. A single 511-symbol loop therefore passes through every symbol class. When self-test is not selected, the same register loads user symbols, or it fills idle byte times with a comma character.

On the receive side, a checker keeps its own copy of the same LFSR. It stays in a hunting state until it receives the loop-start character D0.0, which appears exactly once per loop. After that it runs in lockstep with the generator. It pulses an error output for every received symbol that differs from the expected one, and it pulses a ready output once per completed loop. In a loopback arrangement the transmit outputs feed the receive inputs, and the two status outputs report how the test is going.

Top module: `bist_loop_unit`

## Requirements
- R1: While `bist_en_n` is HIGH the block is in normal mode, and `chk_err` and `chk_ready` stay 0 from the following cycle onward.
- R2: In normal mode, if `tx_load` is 1 at a clock edge, the three inputs `tx_data_in`, `tx_spec_in` and `tx_viol_in` appear on the transmit outputs after that edge. If `tx_load` is 0, the outputs carry the idle comma: byte 0xBC, special 1, violation 0.
- R3: At the first edge where `bist_en_n` is sampled LOW, the transmit outputs become D0.0 (byte 0x00, special 0, violation 0). After that, each edge advances a 9-bit LFSR, which shifts left and feeds in bit8 XOR bit4 (polynomial x^9+x^5+1), starting from the seed 0x100. The symbol stream repeats every 511 byte times.
- R4: A state s maps to a symbol as follows. If s[8]=1, the symbol is a data byte s[7:0]. If s[8]=0, the symbol is a special character with byte s[7:0], and it is also a violation when s[7:4]=0xF. One loop therefore contains all 256 data bytes, 255 special symbols, 16 violation symbols, and D0.0 exactly once.
- R5: In self-test mode the checker reports no error and no ready until it has received D0.0.
- R6: Once the checker has locked, it compares every received symbol with its expected symbol on byte, special flag and violation flag. A mismatch raises `chk_err` for exactly one cycle, in the cycle after the symbol was sampled.
- R7: `chk_ready` is a one-cycle pulse that comes after the last symbol of each loop has been checked. That is 510 edges after D0.0 is sampled, and every 511 cycles after that.
- R8: Leaving self-test and entering it again restarts the generator at D0.0 and returns the checker to hunting.
- R9: A synchronous active-high `rst` sets the transmit outputs to the idle comma and clears `chk_err` and `chk_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| bist_en_n | input | 1 | Self-test select, active low |
| tx_load | input | 1 | Normal-mode load strobe |
| tx_data_in | input | 8 | Normal-mode data byte |
| tx_spec_in | input | 1 | Normal-mode special-character flag |
| tx_viol_in | input | 1 | Normal-mode violation flag |
| tx_data | output | 8 | Transmitted byte |
| tx_spec | output | 1 | Transmitted special flag |
| tx_viol | output | 1 | Transmitted violation flag |
| rx_data | input | 8 | Received byte |
| rx_spec | input | 1 | Received special flag |
| rx_viol | input | 1 | Received violation flag |
| chk_err | output | 1 | One-cycle mismatch pulse |
| chk_ready | output | 1 | One-cycle loop-complete pulse |

## Verification
The bench builds the block with its package defaults: an 8-bit byte and a 9-bit LFSR, which give a 511-symbol loop. With these values the bench can walk a full loop and a second loop, count the coverage of every symbol class, and time two consecutive ready pulses, all in about a thousand cycles. A loopback path in the bench, with a per-cycle corruption mask, makes it possible to reach single-symbol mismatches on each field. The same bench can also drive the checker by hand with garbage, to exercise hunting behaviour and a lock that is followed immediately by a mismatch.

// File: rtl/bist_pkg.sv
package bist_pkg;

    localparam int BYTE_W   = 8;
    localparam int LFSR_W   = BYTE_W + 1;
    localparam int LOOP_LEN = (1 << LFSR_W) - 1;
    localparam int POS_W    = $clog2(LOOP_LEN);
    localparam int TAP_B    = LFSR_W - 5;
    localparam int VIOL_HI  = 4;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef struct packed {
        logic              viol;
        logic              spec;
        logic [BYTE_W-1:0] data;
    } sym_t;

    localparam lfsr_t SEED = lfsr_t'(1) << (LFSR_W - 1);
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hBC;
    localparam sym_t IDLE_SYM = '{viol: 1'b0, spec: 1'b1, data: IDLE_BYTE};

    // One step of x^9 + x^5 + 1 (left shift, feedback into bit 0)
    function automatic lfsr_t lfsr_step(lfsr_t s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[TAP_B]};
    endfunction

    // State to symbol: top bit set means data, clear means special
    function automatic sym_t lfsr_to_sym(lfsr_t s);
        sym_t y;
        y.data = s[BYTE_W-1:0];
        y.spec = ~s[LFSR_W-1];
        y.viol = ~s[LFSR_W-1] & (&s[BYTE_W-1:BYTE_W-VIOL_HI]);
        return y;
    endfunction

    // Inverse of the mapping, so the symbol register itself holds the state
    function automatic lfsr_t sym_to_lfsr(sym_t y);
        return {~y.spec, y.data};
    endfunction

endpackage

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen
    import bist_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bist_on,
    input  logic load,
    input  sym_t din,
    output sym_t dout
);

    logic bist_q;
    sym_t hold_q;
    sym_t hold_d;

    always_comb begin
        if (!bist_on) begin
            hold_d = load ? din : IDLE_SYM;
        end else if (!bist_q) begin
            hold_d = lfsr_to_sym(SEED);
        end else begin
            hold_d = lfsr_to_sym(lfsr_step(sym_to_lfsr(hold_q)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bist_q <= 1'b0;
            hold_q <= IDLE_SYM;
        end else begin
            bist_q <= bist_on;
            hold_q <= hold_d;
        end
    end

    assign dout = hold_q;

endmodule

// File: rtl/bist_pattern_chk.sv
module bist_pattern_chk
    import bist_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bist_on,
    input  sym_t rx,
    output logic err,
    output logic ready
);

    typedef enum logic {HUNT, RUN} chk_state_t;

    chk_state_t       state_q;
    lfsr_t            exp_q;
    logic [POS_W-1:0] pos_q;
    sym_t             exp_sym;

    assign exp_sym = lfsr_to_sym(exp_q);

    always_ff @(posedge clk) begin
        if (rst || !bist_on) begin
            state_q <= HUNT;
            exp_q   <= SEED;
            pos_q   <= '0;
            err     <= 1'b0;
            ready   <= 1'b0;
        end else begin
            err   <= 1'b0;
            ready <= 1'b0;
            if (state_q == HUNT) begin
                if (rx == lfsr_to_sym(SEED)) begin
                    state_q <= RUN;
                    exp_q   <= lfsr_step(SEED);
                    pos_q   <= POS_W'(1);
                end
            end else begin
                err   <= (rx != exp_sym);
                exp_q <= lfsr_step(exp_q);
                if (pos_q == POS_W'(LOOP_LEN - 1)) begin
                    pos_q <= '0;
                    ready <= 1'b1;
                end else begin
                    pos_q <= pos_q + POS_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/bist_loop_unit.sv
module bist_loop_unit
    import bist_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bist_en_n,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_data_in,
    input  logic              tx_spec_in,
    input  logic              tx_viol_in,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_spec,
    output logic              tx_viol,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_spec,
    input  logic              rx_viol,
    output logic              chk_err,
    output logic              chk_ready
);

    logic bist_on;
    sym_t tx_in_sym;
    sym_t tx_sym;
    sym_t rx_sym;

    assign bist_on   = ~bist_en_n;
    assign tx_in_sym = '{viol: tx_viol_in, spec: tx_spec_in, data: tx_data_in};
    assign rx_sym    = '{viol: rx_viol, spec: rx_spec, data: rx_data};

    bist_pattern_gen u_gen (
        .clk     (clk),
        .rst     (rst),
        .bist_on (bist_on),
        .load    (tx_load),
        .din     (tx_in_sym),
        .dout    (tx_sym)
    );

    assign tx_data = tx_sym.data;
    assign tx_spec = tx_sym.spec;
    assign tx_viol = tx_sym.viol;

    bist_pattern_chk u_chk (
        .clk     (clk),
        .rst     (rst),
        .bist_on (bist_on),
        .rx      (rx_sym),
        .err     (chk_err),
        .ready   (chk_ready)
    );

endmodule

// File: rtl/bist_loop_unit_sva.sv
module bist_loop_unit_sva
    import bist_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bist_en_n,
    input logic              tx_load,
    input logic [BYTE_W-1:0] tx_data_in,
    input logic              tx_spec_in,
    input logic              tx_viol_in,
    input logic [BYTE_W-1:0] tx_data,
    input logic              tx_spec,
    input logic              tx_viol,
    input logic [BYTE_W-1:0] rx_data,
    input logic              rx_spec,
    input logic              rx_viol,
    input logic              chk_err,
    input logic              chk_ready
);

    assert_quiet_normal_R1: assert property (@(posedge clk) disable iff (rst)
        $past(bist_en_n) |-> (!chk_err && !chk_ready));

    assert_idle_fill_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(bist_en_n) && !$past(tx_load)) |->
            (tx_data == IDLE_BYTE && tx_spec && !tx_viol));

    assert_user_load_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(bist_en_n) && $past(tx_load) && !$past(rst)) |->
            (tx_data == $past(tx_data_in) && tx_spec == $past(tx_spec_in)
             && tx_viol == $past(tx_viol_in)));

    assert_loop_start_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(bist_en_n) |=> (tx_data == '0 && !tx_spec && !tx_viol));

    assert_viol_only_special_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(bist_en_n) && !$past(rst) && !tx_spec) |-> !tx_viol);

    assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        chk_ready |=> !chk_ready);

endmodule

bind bist_loop_unit bist_loop_unit_sva u_sva (.*);

// File: tb/bist_loop_unit_tb.sv
module bist_loop_unit_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       bist_en_n;
    logic       tx_load;
    logic [7:0] tx_data_in;
    logic       tx_spec_in;
    logic       tx_viol_in;
    logic [7:0] tx_data;
    logic       tx_spec;
    logic       tx_viol;
    logic [7:0] rx_data;
    logic       rx_spec;
    logic       rx_viol;
    logic       chk_err;
    logic       chk_ready;

    logic       loop_mode;
    logic [9:0] flip;
    logic [9:0] man_rx;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        if (loop_mode) {rx_viol, rx_spec, rx_data} = {tx_viol, tx_spec, tx_data} ^ flip;
        else           {rx_viol, rx_spec, rx_data} = man_rx;
    end

    bist_loop_unit u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] m_step(logic [8:0] s);
        return {s[7:0], s[8] ^ s[4]};
    endfunction

    function automatic logic [9:0] m_sym(logic [8:0] s);
        return {~s[8] & (s[7:4] == 4'hF), ~s[8], s[7:0]};
    endfunction

    function automatic logic [9:0] tx_now();
        return {tx_viol, tx_spec, tx_data};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; bist_en_n = 1'b1; tx_load = 1'b0;
        tx_data_in = '0; tx_spec_in = 1'b0; tx_viol_in = 1'b0;
        loop_mode = 1'b1; flip = '0; man_rx = '0;
        cyc(3);
        check("R9 reset tx", {22'd0, tx_now()}, {22'd0, 10'h1BC});
        check("R9 reset status", {30'd0, chk_err, chk_ready}, 32'd0);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic t_normal;
        int bad = 0;
        tx_load = 1'b1; tx_data_in = 8'hA5; tx_spec_in = 1'b0; tx_viol_in = 1'b0;
        cyc(1);
        check("R2 load data", {22'd0, tx_now()}, {22'd0, 10'h0A5});
        tx_data_in = 8'h3C; tx_spec_in = 1'b1; tx_viol_in = 1'b1;
        cyc(1);
        check("R2 load flags", {22'd0, tx_now()}, {22'd0, 10'h33C});
        tx_load = 1'b0;
        cyc(1);
        check("R2 idle fill", {22'd0, tx_now()}, {22'd0, 10'h1BC});
        loop_mode = 1'b0; man_rx = 10'h000;
        for (int i = 0; i < 20; i++) begin
            cyc(1);
            if (chk_err || chk_ready) bad++;
        end
        check("R1 quiet in normal mode", bad, 0);
        loop_mode = 1'b1;
    endtask

    task automatic t_gen_seq;
        logic [8:0] st = 9'h100;
        logic [255:0] seen = '0;
        int mism = 0, n_spec = 0, n_viol = 0, n_d00 = 0;
        bist_en_n = 1'b0;
        cyc(1);
        check("R3 first symbol D0.0", {22'd0, tx_now()}, 32'd0);
        for (int i = 0; i < 511; i++) begin
            logic [9:0] e = m_sym(st);
            if (tx_now() !== e) begin
                if (mism == 0) $display("FAIL R3 step %0d actual=%0h expected=%0h", i, tx_now(), e);
                mism++;
            end
            if (!tx_spec) seen[tx_data] = 1'b1;
            if (tx_spec) n_spec++;
            if (tx_viol) n_viol++;
            if (tx_now() == 10'h000) n_d00++;
            st = m_step(st);
            cyc(1);
        end
        check("R3 sequence matches LFSR", mism, 0);
        check("R3 loop repeats after 511", {22'd0, tx_now()}, 32'd0);
        check("R4 all data bytes", {31'd0, &seen}, 32'd1);
        check("R4 special count", n_spec, 255);
        check("R4 violation count", n_viol, 16);
        check("R4 D0.0 once", n_d00, 1);
    endtask

    task automatic t_ready;
        int r1 = -1, r2 = -1, nr = 0, ne = 0;
        bist_en_n = 1'b1;
        cyc(2);
        bist_en_n = 1'b0;
        cyc(1);
        check("R8 restart at D0.0", {22'd0, tx_now()}, 32'd0);
        for (int k = 1; k <= 1100; k++) begin
            if (chk_ready) begin
                nr++;
                if (r1 < 0) r1 = k; else if (r2 < 0) r2 = k;
            end
            if (chk_err) ne++;
            cyc(1);
        end
        check("R7 first ready cycle", r1, 512);
        check("R7 second ready cycle", r2, 1023);
        check("R7 ready count", nr, 2);
        check("R6 no false errors", ne, 0);
    endtask

    task automatic t_inject;
        flip = 10'h004;
        cyc(1);
        flip = '0;
        check("R6 data mismatch flagged", {31'd0, chk_err}, 32'd1);
        cyc(1);
        check("R6 error lasts one cycle", {31'd0, chk_err}, 32'd0);
        cyc(5);
        flip = 10'h100;
        cyc(1);
        flip = '0;
        check("R6 special mismatch flagged", {31'd0, chk_err}, 32'd1);
        cyc(1);
        flip = 10'h200;
        cyc(1);
        flip = '0;
        check("R6 violation mismatch flagged", {31'd0, chk_err}, 32'd1);
        cyc(1);
        check("R6 error clears", {31'd0, chk_err}, 32'd0);
    endtask

    task automatic t_hunt;
        int bad = 0;
        bist_en_n = 1'b1;
        loop_mode = 1'b0;
        man_rx = 10'h055;
        cyc(2);
        bist_en_n = 1'b0;
        for (int i = 0; i < 600; i++) begin
            cyc(1);
            if (chk_err || chk_ready) bad++;
        end
        check("R5 no status before D0.0", bad, 0);
        man_rx = 10'h000;
        cyc(1);
        man_rx = 10'h055;
        check("R5 lock cycle quiet", {31'd0, chk_err}, 32'd0);
        cyc(1);
        check("R6 mismatch right after lock", {31'd0, chk_err}, 32'd1);
        loop_mode = 1'b1;
        bist_en_n = 1'b1;
        cyc(2);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_gen_seq();
        t_ready();
        t_inject();
        t_hunt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule